// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits beside the receive path of an Ethernet MAC and decides whether a frame with a group (multicast) destination address should be kept. The six destination-address bytes arrive one per clock on a byte stream, and a start-of-frame pulse marks the first of them. Byte 0 is the first byte on the wire (the leftmost byte of the written address, e.g. `01` in `01-1C-23-17-4A-CB`) and fills address bits 7:0. Byte 5 fills bits 47:40. While the bytes stream in, the block folds each one into a 6-bit hash code. Bit i of the code is the XOR parity of byte i.

The code selects one of 64 one-bit filter entries. One cycle after the sixth byte, the block pulses a decision strobe together with the accept flag, a multicast flag and the hash code. An address counts as multicast only when bit 0 of byte 0 is 1. Any other address skips the table and is never accepted by this block.

Software programs the entries through a word-addressed register port. The entry for hash code h sits at word address 0x40 + h, and only bit 0 of that word carries the entry.

The control is a four-state machine:
- `ST_IDLE`: the state after reset; bytes are ignored.
- `ST_COLLECT`: bytes are being gathered.
- `ST_DECIDE`: the one-cycle decision.
- `ST_DONE`: trailing bytes are ignored.

Transitions:
- IDLE→COLLECT on start-of-frame.
- COLLECT→COLLECT on bytes 0 to 4.
- COLLECT→DECIDE on byte 5.
- DECIDE→DONE by itself.
- DONE→COLLECT on start-of-frame.
- Any state→COLLECT (or DECIDE, if it is the last byte) on start-of-frame, which restarts the byte count.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset the decision strobe is low and all 64 filter entries read back as 0 (reject).
- R2: Hash bit i (i = 0..5) equals the XOR of all bits of the i-th address byte after start-of-frame. For address 01-1C-23-17-4A-CB, driven in that order, the hash code is 0x37.
- R3: `decision_vld_o` is high for exactly one cycle: the cycle after the one in which the sixth byte is taken. In that cycle `accept_o` equals the table entry selected by `hash_code_o` when the address is multicast, and `accept_o` is low in every other cycle.
- R4: The address is multicast when bit 0 of byte 0 is 1. For a non-multicast address, `mcast_o` and `accept_o` are 0 in the decision cycle, whatever the table holds.
- R5: A write to word address 0x40 + h stores `reg_wdata_i[0]` in entry h, visible from the next cycle. A read of 0x40 + h returns the entry in bit 0 and zeros in bits 31:1, in the same cycle.
- R6: Reads of addresses outside 0x40 to 0x7F return 0, and writes there leave every entry unchanged.
- R7: Bytes that arrive before any start-of-frame, or after the sixth byte of a frame, are ignored until the next start-of-frame and never produce a decision.
- R8: A start-of-frame pulse restarts the byte count. If a byte is valid in the same cycle, that byte is byte 0. Otherwise the next valid byte is byte 0. A restart in the middle of an address discards the partial address.
- R9: A write to the entry being looked up, made in the decision cycle, does not affect that decision: the old value decides. The new value is stored and read back afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame pulse, restarts the byte count |
| byte_vld_i | input | 1 | Address byte valid |
| byte_i | input | 8 | Destination address byte, first byte first |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data (bit 0 used) |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| decision_vld_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted by the hash table |
| mcast_o | output | 1 | Address is multicast |
| hash_code_o | output | 6 | Hash code of the address |

## Verification
The decision outputs are due one cycle after the clock edge that takes the sixth byte. The bench drives the byte on a falling edge and samples the strobe, accept, multicast flag and hash code at the very next falling edge. It also checks that the strobe is low on the falling edge after that one. Register read data is combinational, so it is sampled a moment after the address is driven in the same cycle. A write is checked by a read in the cycle after the write strobe. For the same-cycle write-versus-lookup case, the write is driven in the decision cycle itself: the decision is sampled in that cycle, and the stored value is read in the next one.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_DONE    = 2'd3
    } mhf_state_e;

endpackage

// File: rtl/mhf_hash_acc.sv
module mhf_hash_acc
    import mhf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              decide_o,
    output logic [HASH_W-1:0] hash_o,
    output logic              mcast_o
);

    localparam int IDX_W = (HASH_W > 1) ? $clog2(HASH_W) : 1;
    localparam int LAST  = HASH_W - 1;

    mhf_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [HASH_W-1:0] hash_q;
    logic              mc_q;
    logic              take;
    logic              last_byte;

    // A byte counts only inside an address or alongside start-of-frame.
    assign take      = byte_vld_i && (sof_i || state_q == ST_COLLECT);
    assign cur_idx   = sof_i ? '0 : idx_q;
    assign last_byte = take && (cur_idx == IDX_W'(LAST));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (take) begin
            state_d = last_byte ? ST_DECIDE : ST_COLLECT;
        end else if (sof_i) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: state_d = ST_COLLECT;
                ST_DECIDE:  state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Byte index, hash bits and the multicast flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            hash_q <= '0;
            mc_q   <= 1'b0;
        end else if (take) begin
            hash_q[cur_idx] <= ^byte_i;
            if (cur_idx == '0) mc_q <= byte_i[0];
            if (!last_byte) idx_q <= cur_idx + 1'b1;
        end else if (sof_i) begin
            idx_q <= '0;
        end
    end

    // Outputs.
    always_comb begin
        decide_o = (state_q == ST_DECIDE);
        hash_o   = hash_q;
        mcast_o  = mc_q;
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(LAST)); // R7
    AST_LAST_TO_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> state_q == ST_DECIDE); // R3
    AST_DECIDE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DECIDE |=> state_q != ST_DECIDE); // R3
    AST_IGNORE_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_DONE) && !sof_i)
        |=> ($stable(hash_q) && $stable(mc_q))); // R7

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
    parameter int HASH_W     = 6,
    parameter int REG_AW     = 8,
    parameter int REG_DW     = 32,
    parameter int TABLE_BASE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic [HASH_W-1:0] lookup_i,
    output logic              lookup_hit_o
);

    localparam int                DEPTH = 1 << HASH_W;
    localparam logic [REG_AW:0]   LO    = (REG_AW+1)'(TABLE_BASE);
    localparam logic [REG_AW:0]   HI    = (REG_AW+1)'(TABLE_BASE + DEPTH);

    logic [DEPTH-1:0]  entry_q;
    logic [REG_AW-1:0] off;
    logic [HASH_W-1:0] slot;
    logic              in_range;
    logic              unused_bits;

    assign in_range    = ({1'b0, reg_addr_i} >= LO) && ({1'b0, reg_addr_i} < HI);
    assign off         = reg_addr_i - REG_AW'(TABLE_BASE);
    assign slot        = off[HASH_W-1:0];
    assign unused_bits = ^{reg_wdata_i[REG_DW-1:1], off};

    // One enable flop per hash code.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (reg_wr_i && in_range && slot == HASH_W'(g))
                bit_q <= reg_wdata_i[0];
        end
        assign entry_q[g] = bit_q;
    end

    assign reg_rdata_o  = in_range ? {{(REG_DW-1){1'b0}}, entry_q[slot]} : '0;
    assign lookup_hit_o = entry_q[lookup_i];

    AST_OUT_OF_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !in_range) |=> $stable(entry_q)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> $stable(entry_q)); // R5
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && in_range) |=> entry_q[$past(slot)] == $past(reg_wdata_i[0])); // R5
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[REG_DW-1:1] == '0); // R5

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int BYTE_W     = 8,
    parameter int HASH_W     = 6,
    parameter int REG_AW     = 8,
    parameter int REG_DW     = 32,
    parameter int TABLE_BASE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              decision_vld_o,
    output logic              accept_o,
    output logic              mcast_o,
    output logic [HASH_W-1:0] hash_code_o
);

    logic              decide;
    logic              mc;
    logic              hit;
    logic [HASH_W-1:0] hash;

    mhf_hash_acc #(.BYTE_W(BYTE_W), .HASH_W(HASH_W)) u_hash (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .decide_o   (decide),
        .hash_o     (hash),
        .mcast_o    (mc)
    );

    mhf_table #(
        .HASH_W(HASH_W), .REG_AW(REG_AW), .REG_DW(REG_DW), .TABLE_BASE(TABLE_BASE)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .lookup_i     (hash),
        .lookup_hit_o (hit)
    );

    // The lookup reads the stored value, so a write landing at the end of
    // the decision cycle cannot alter that decision.
    assign decision_vld_o = decide;
    assign mcast_o        = decide && mc;
    assign accept_o       = decide && mc && hit;
    assign hash_code_o    = hash;

    AST_ACCEPT_IN_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> decision_vld_o); // R3
    AST_NONMC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_vld_o && !mcast_o) |-> !accept_o); // R4

endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;

    typedef logic [7:0] addr_t [6];

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sof_i, byte_vld_i, reg_wr_i;
    logic [7:0]  byte_i, reg_addr_i;
    logic [31:0] reg_wdata_i, reg_rdata_o;
    logic        decision_vld_o, accept_o, mcast_o;
    logic [5:0]  hash_code_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit tbl_model [64];

    always #2 clk = ~clk;

    mcast_hash_filter dut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .decision_vld_o(decision_vld_o), .accept_o(accept_o),
        .mcast_o(mcast_o), .hash_code_o(hash_code_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input addr_t a);
        logic [5:0] h;
        for (int i = 0; i < 6; i++) h[i] = ^a[i];
        return h;
    endfunction

    function automatic addr_t make_addr(input int h, input bit mc, input int salt);
        addr_t a;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = 8'((i * 53 + h * 29 + salt) & 255);
            if (i == 0) b[0] = mc;
            if ((^b) != h[i]) b[7] = ~b[7];
            a[i] = b;
        end
        return a;
    endfunction

    task automatic reg_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = addr; reg_wdata_i = data;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] addr, output logic [31:0] data);
        @(negedge clk);
        reg_addr_i = addr;
        #1 data = reg_rdata_o;
    endtask

    // Drives six bytes; returns at the falling edge inside the decision cycle.
    task automatic send_frame(input addr_t a);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = a[i];
        end
        @(negedge clk);
        sof_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    endtask

    task automatic check_decision(input addr_t a, input string tag);
        logic [5:0] h;
        bit mc;
        h  = hash_of(a);
        mc = a[0][0];
        #1;
        chk(decision_vld_o === 1'b1, {tag, " R3 strobe"}, decision_vld_o, 1);
        chk(hash_code_o === h, {tag, " R2 hash"}, hash_code_o, h);
        chk(mcast_o === mc, {tag, " R4 mcast"}, mcast_o, mc);
        chk(accept_o === (mc && tbl_model[h]), {tag, " R3 accept"}, accept_o, mc && tbl_model[h]);
        @(negedge clk);
        #1 chk(decision_vld_o === 1'b0 && accept_o === 1'b0, {tag, " R3 one cycle"},
               decision_vld_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        addr_t a, ex;

        rst_n = 1'b0; sof_i = 0; byte_vld_i = 0; byte_i = 0;
        reg_wr_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk(decision_vld_o === 1'b0, "R1 strobe after reset", decision_vld_o, 0);
        for (int h = 0; h < 64; h++) begin
            reg_read(8'(64 + h), rd);
            chk(rd === 32'd0, "R1 entry after reset", rd, 0);
        end

        // R7: stray bytes before any start-of-frame
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            byte_vld_i = 1'b1; byte_i = 8'(k * 37);
            #1 chk(decision_vld_o === 1'b0, "R7 no decision without sof", decision_vld_o, 0);
        end
        @(negedge clk);
        byte_vld_i = 1'b0;
        #1 chk(decision_vld_o === 1'b0, "R7 no decision without sof", decision_vld_o, 0);

        // R5: program every entry and read it back
        for (int h = 0; h < 64; h++) begin
            tbl_model[h] = bit'(((h * 11) >> 3) ^ h);
            reg_write(8'(64 + h), {31'h5A5A5A5A, tbl_model[h]});
        end
        for (int h = 0; h < 64; h++) begin
            reg_read(8'(64 + h), rd);
            chk(rd === {31'd0, tbl_model[h]}, "R5 readback", rd, tbl_model[h]);
        end

        // R6: out-of-range reads and writes
        for (int ad = 0; ad < 256; ad++) begin
            if (ad >= 64 && ad < 128) continue;
            reg_read(8'(ad), rd);
            chk(rd === 32'd0, "R6 read outside table", rd, 0);
        end
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_write(8'h3F, 32'hFFFF_FFFF);
        reg_write(8'h80, 32'h0000_0000);
        reg_write(8'hFF, 32'hFFFF_FFFF);
        for (int h = 0; h < 64; h++) begin
            reg_read(8'(64 + h), rd);
            chk(rd === {31'd0, tbl_model[h]}, "R6 table unchanged", rd, tbl_model[h]);
        end

        // R2/R3/R4: sweep every hash code, multicast and not
        for (int h = 0; h < 64; h++) begin
            for (int m = 0; m < 2; m++) begin
                a = make_addr(h, bit'(m), m * 101);
                send_frame(a);
                check_decision(a, m ? "sweep mc" : "sweep uc R4");
            end
        end

        // R2: the worked example 01-1C-23-17-4A-CB -> 0x37 at word 0x77
        ex[0] = 8'h01; ex[1] = 8'h1C; ex[2] = 8'h23;
        ex[3] = 8'h17; ex[4] = 8'h4A; ex[5] = 8'hCB;
        reg_write(8'h77, 32'd0);
        tbl_model[55] = 1'b0;
        send_frame(ex);
        #1 chk(hash_code_o === 6'h37, "R2 example hash", hash_code_o, 6'h37);
        chk(accept_o === 1'b0, "R2 example rejected while entry clear", accept_o, 0);
        @(negedge clk);
        reg_write(8'h77, 32'd1);
        tbl_model[55] = 1'b1;
        send_frame(ex);
        check_decision(ex, "R2 example accepted");

        // R7: trailing bytes after the sixth are ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = ex[i];
        end
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            sof_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'hFF;
            #1 chk(decision_vld_o === (k == 0), "R7 trailing bytes", decision_vld_o, k == 0);
        end
        @(negedge clk);
        byte_vld_i = 1'b0;

        // R8: restart in the middle of an address
        a = make_addr(12, 1'b1, 7);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = 8'hFE - 8'(i);
        end
        send_frame(a);
        check_decision(a, "R8 restart mid address");

        // R8: sof alone arms; the next valid byte is byte 0
        a = make_addr(45, 1'b1, 3);
        @(negedge clk);
        sof_i = 1'b1; byte_vld_i = 1'b0;
        @(negedge clk);
        sof_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_vld_i = 1'b1; byte_i = a[i];
            #1 chk(decision_vld_o === 1'b0, "R8 no early decision", decision_vld_o, 0);
        end
        @(negedge clk);
        byte_vld_i = 1'b0;
        check_decision(a, "R8 sof without byte");

        // R9: write to the looked-up entry in the decision cycle
        send_frame(ex);
        reg_wr_i = 1'b1; reg_addr_i = 8'h77; reg_wdata_i = 32'd0;
        #1 chk(accept_o === 1'b1, "R9 old value decides (1->0)", accept_o, 1);
        @(negedge clk);
        reg_wr_i = 1'b0;
        reg_read(8'h77, rd);
        chk(rd === 32'd0, "R9 new value stored", rd, 0);

        send_frame(ex);
        reg_wr_i = 1'b1; reg_addr_i = 8'h77; reg_wdata_i = 32'd1;
        #1 chk(accept_o === 1'b0, "R9 old value decides (0->1)", accept_o, 0);
        @(negedge clk);
        reg_wr_i = 1'b0;
        reg_read(8'h77, rd);
        chk(rd === 32'd1, "R9 new value stored", rd, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule